// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is the command front end of a two-bank, 2M x 16 low-power SDRAM device. On every rising clock edge it samples the four active-low strobes (chip select, row strobe, column strobe, write enable), the bank-select bit and the 11-bit address. It turns them into one command: activate, read, write, precharge, auto refresh, load mode or no-op. From those commands it keeps a record of which banks have a row open, and which row each one holds. It hands each legal column access to the array with its bank and column. It also counts out the burst that the access started.

The block holds both mode registers. The base register sets the burst length. The extended register selects which banks self refresh keeps, and the block exports that choice as a per-bank refresh mask. When clock enable is sampled low, a small state machine records which low-power mode the device has entered. It judges the mode from the bank and burst state at that edge.

Each bank runs a two-state machine. `BK_IDLE` moves to `BK_OPEN` on an activate to that bank. `BK_OPEN` moves back to `BK_IDLE` on a precharge that names the bank, or when an auto-precharge burst on that bank ends. The power machine has five states: `PW_RUN`, `PW_PRE_PD`, `PW_SELF_REF`, `PW_ACT_PD` and `PW_SUSPEND`. It leaves `PW_RUN` for one of the other four on the first edge that samples clock enable low. From any of those four it returns to `PW_RUN` on the first edge that samples clock enable high.

Top module: `sdram_cmd_front`

## Requirements
- R1: While `cke` is high, the pin code {cs_n,ras_n,cas_n,we_n} selects the command: 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 auto refresh, 0000 load mode; any other code is a no-op. A read or write to an open bank pulses `acc_valid_o` for one cycle after the edge, with `acc_write_o` high for a write, `acc_bank_o` = `ba` and `acc_col_o` = `addr[8:0]`. The access fields otherwise hold their last value.
- R2: When `cs_n` is high at an edge, the edge is a no-op: no bank, register, flag or access output changes because of it.
- R3: Activate sets the bank named by `ba` open, and stores `addr[10:0]` as that bank's row in `row_o` (bank i in bits [11i+10:11i]). The row value is kept after the bank closes. Activate wins over a close that lands on the same bank at the same edge.
- R4: Precharge with `addr[10]` low closes only bank `ba`; with `addr[10]` high it closes both banks.
- R5: A read or write to an idle bank sets the sticky `proto_err_o` and produces no access pulse, burst or auto precharge.
- R6: A legal read or write starts a burst whose length comes from `mode_reg_o[2:0]`: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and any other value gives 1. `burst_busy_o` is high for that many clock-enabled edges. If `addr[10]` was high on the access, its bank closes at the edge that ends the burst. A new legal access restarts the count and replaces any pending auto precharge.
- R7: Load mode with `ba`=0 writes `addr` into `mode_reg_o`.
- R8: Load mode with `ba`=1 writes `addr` into `ext_mode_o` only if `addr[10:8]` is zero, both banks are idle and no burst is running. Otherwise `ext_mode_o` keeps its value and the sticky `emr_err_o` is set.
- R9: `refresh_mask_o` (bit i = bank i kept) is 2'b01 when `ext_mode_o[2:0]`=001 and `ext_mode_o[7]`=0. It is 2'b10 when `ext_mode_o[2:0]`=001 and `ext_mode_o[7]`=1. It is 2'b11 for every other value of `ext_mode_o[2:0]`.
- R10: At an edge in `PW_RUN` with `cke` low, `pwr_mode_o` is set as follows, the first matching rule applying: 4 (clock suspend) if a burst is running; else 3 (active power-down) if a row is open; else 2 (self refresh) if the pin code is auto refresh; else 1 (precharge power-down).
- R11: In any low-power state, an edge with `cke` high returns `pwr_mode_o` to 0 (run). Edges with `cke` low execute no command, and the burst count holds over them.
- R12: After reset, both banks are idle, every row, register and flag is zero, `acc_valid_o` and `burst_busy_o` are low, `refresh_mask_o` is 2'b11 and `pwr_mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | 11 | Row, column or op-code address |
| bank_open_o | output | 2 | Per-bank row-open flags |
| row_o | output | 22 | Last activated row of each bank |
| acc_valid_o | output | 1 | One-cycle pulse for a legal access |
| acc_write_o | output | 1 | Access is a write |
| acc_bank_o | output | 1 | Bank of the access |
| acc_col_o | output | 9 | Column of the access |
| burst_busy_o | output | 1 | Burst in progress |
| proto_err_o | output | 1 | Sticky: access to idle bank |
| mode_reg_o | output | 11 | Base mode register |
| ext_mode_o | output | 11 | Extended mode register |
| emr_err_o | output | 1 | Sticky: rejected extended load |
| refresh_mask_o | output | 2 | Banks kept during self refresh |
| pwr_mode_o | output | 3 | 0 run, 1 precharge PD, 2 self refresh, 3 active PD, 4 suspend |

## Verification
The assertions assume the strobes, bank select and address are never unknown at a sampled edge. They also assume `rst_n` is asserted before the first edge, so every state register starts from its reset value. The bench drives only defined levels and changes its inputs on the falling edge only. It holds reset over the first edges. Its random mix includes activates to open banks, accesses to idle banks and out-of-order mode loads. These are still legal pin values, and the design must flag them rather than misbehave.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;
    localparam int NBANK = 2;
    localparam int BA_W  = 1;
    localparam int BCNT_W = 4;

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE, CMD_PRE, CMD_AREF, CMD_LMR
    } cmd_e;

    typedef enum logic [2:0] {
        PW_RUN      = 3'd0,
        PW_PRE_PD   = 3'd1,
        PW_SELF_REF = 3'd2,
        PW_ACT_PD   = 3'd3,
        PW_SUSPEND  = 3'd4
    } pwr_e;

    typedef enum logic { BK_IDLE, BK_OPEN } bank_e;
endpackage

// File: rtl/sdcf_decode.sv
module sdcf_decode
    import sdcf_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_AREF;
                3'b000:  cmd = CMD_LMR;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdcf_bank.sv
module sdcf_bank
    import sdcf_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    bank_e state_q, state_d;
    logic [ROW_W-1:0] row_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: if (act_i) state_d = BK_OPEN;
            BK_OPEN: if (close_i && !act_i) state_d = BK_IDLE;
            default: state_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (act_i) row_q <= row_i;
        end
    end

    assign open_o = (state_q == BK_OPEN);
    assign row_o  = row_q;

    p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> open_o && row_o == $past(row_i));
    p_close_idles_r4: assert property (@(posedge clk) disable iff (!rst_n)
        close_i && !act_i |=> !open_o);
endmodule

// File: rtl/sdcf_modereg.sv
module sdcf_modereg #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lmr_i,
    input  logic          ba_i,
    input  logic [AW-1:0] addr_i,
    input  logic          banks_idle_i,
    input  logic          burst_busy_i,
    output logic [AW-1:0] mr_o,
    output logic [AW-1:0] emr_o,
    output logic          err_o,
    output logic [1:0]    mask_o
);
    logic [AW-1:0] mr_q, emr_q;
    logic          err_q;
    logic          ext_ld, ext_ok;

    assign ext_ld = lmr_i && ba_i;
    assign ext_ok = (addr_i[10:8] == 3'b000) && banks_idle_i && !burst_busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr_q  <= '0;
            emr_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (lmr_i && !ba_i) mr_q <= addr_i;
            if (ext_ld && ext_ok) emr_q <= addr_i;
            if (ext_ld && !ext_ok) err_q <= 1'b1;
        end
    end

    always_comb begin
        if (emr_q[2:0] == 3'b001) mask_o = emr_q[7] ? 2'b10 : 2'b01;
        else                      mask_o = 2'b11;
    end

    assign mr_o  = mr_q;
    assign emr_o = emr_q;
    assign err_o = err_q;

    p_emr_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ld && !ext_ok |=> $stable(emr_o) && err_o);
    p_one_bank_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        emr_o[2:0] == 3'b001 |-> $countones(mask_o) == 1);
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
    import sdcf_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cke,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic                   ba,
    input  logic [ROW_W-1:0]       addr,
    output logic [NBANK-1:0]       bank_open_o,
    output logic [NBANK*ROW_W-1:0] row_o,
    output logic                   acc_valid_o,
    output logic                   acc_write_o,
    output logic                   acc_bank_o,
    output logic [COL_W-1:0]       acc_col_o,
    output logic                   burst_busy_o,
    output logic                   proto_err_o,
    output logic [ROW_W-1:0]       mode_reg_o,
    output logic [ROW_W-1:0]       ext_mode_o,
    output logic                   emr_err_o,
    output logic [1:0]             refresh_mask_o,
    output logic [2:0]             pwr_mode_o
);
    localparam int AP_BIT = 10;

    cmd_e raw_cmd, cmd;
    logic rw, rw_ok, ap_done, any_open;
    logic [BCNT_W-1:0] rem_q, bl;
    logic ap_pend_q, ap_bank_q;
    logic acc_v_q, acc_w_q, acc_b_q, perr_q;
    logic [COL_W-1:0] acc_c_q;
    pwr_e pwr_q, pwr_d;

    sdcf_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(raw_cmd)
    );

    assign cmd      = cke ? raw_cmd : CMD_NOP;
    assign rw       = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    assign rw_ok    = rw && bank_open_o[ba];
    assign any_open = |bank_open_o;
    assign ap_done  = cke && ap_pend_q && (rem_q == BCNT_W'(1)) && !rw_ok;

    always_comb begin
        unique case (mode_reg_o[2:0])
            3'd1:    bl = BCNT_W'(2);
            3'd2:    bl = BCNT_W'(4);
            3'd3:    bl = BCNT_W'(8);
            default: bl = BCNT_W'(1);
        endcase
    end

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        localparam logic [BA_W-1:0] IDX = BA_W'(i);
        logic act_i, close_i;
        assign act_i   = (cmd == CMD_ACT) && (ba == IDX);
        assign close_i = ((cmd == CMD_PRE) && (addr[AP_BIT] || ba == IDX))
                       || (ap_done && ap_bank_q == IDX);
        sdcf_bank #(.ROW_W(ROW_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .act_i(act_i), .close_i(close_i),
            .row_i(addr), .open_o(bank_open_o[i]),
            .row_o(row_o[i*ROW_W +: ROW_W])
        );
    end

    sdcf_modereg #(.AW(ROW_W)) u_mr (
        .clk(clk), .rst_n(rst_n), .lmr_i(cmd == CMD_LMR), .ba_i(ba),
        .addr_i(addr), .banks_idle_i(!any_open), .burst_busy_i(burst_busy_o),
        .mr_o(mode_reg_o), .emr_o(ext_mode_o), .err_o(emr_err_o),
        .mask_o(refresh_mask_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q     <= '0;
            ap_pend_q <= 1'b0;
            ap_bank_q <= 1'b0;
            acc_v_q   <= 1'b0;
            acc_w_q   <= 1'b0;
            acc_b_q   <= 1'b0;
            acc_c_q   <= '0;
            perr_q    <= 1'b0;
        end else begin
            acc_v_q <= rw_ok;
            if (rw && !rw_ok) perr_q <= 1'b1;
            if (rw_ok) begin
                acc_w_q   <= (cmd == CMD_WRITE);
                acc_b_q   <= ba;
                acc_c_q   <= addr[COL_W-1:0];
                rem_q     <= bl;
                ap_pend_q <= addr[AP_BIT];
                ap_bank_q <= ba;
            end else if (cke && rem_q != '0) begin
                rem_q <= rem_q - BCNT_W'(1);
                if (ap_done) ap_pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            PW_RUN: begin
                if (!cke) begin
                    if (burst_busy_o)             pwr_d = PW_SUSPEND;
                    else if (any_open)            pwr_d = PW_ACT_PD;
                    else if (raw_cmd == CMD_AREF) pwr_d = PW_SELF_REF;
                    else                          pwr_d = PW_PRE_PD;
                end
            end
            PW_PRE_PD, PW_SELF_REF, PW_ACT_PD, PW_SUSPEND:
                if (cke) pwr_d = PW_RUN;
            default: pwr_d = PW_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_q <= PW_RUN;
        else        pwr_q <= pwr_d;
    end

    assign burst_busy_o = (rem_q != '0);
    assign acc_valid_o  = acc_v_q;
    assign acc_write_o  = acc_w_q;
    assign acc_bank_o   = acc_b_q;
    assign acc_col_o    = acc_c_q;
    assign proto_err_o  = perr_q;
    assign pwr_mode_o   = pwr_q;

    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke && cs_n |=> !acc_valid_o);
    p_idle_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cke && !cs_n && ras_n && !cas_n && !bank_open_o[ba]
        |=> proto_err_o && !acc_valid_o);
    p_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode_o == 3'd0 && !cke && burst_busy_o |=> pwr_mode_o == 3'd4);
    p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_mode_o != 3'd0 && cke |=> pwr_mode_o == 3'd0);
    p_hold_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(burst_busy_o));
endmodule

// File: tb/sim_sdram_cmd_front.sv
`timescale 1ns/1ps
module sim_sdram_cmd_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ba = 1'b0;
    logic [10:0] addr = '0;
    logic [1:0]  bank_open_o, refresh_mask_o;
    logic [21:0] row_o;
    logic        acc_valid_o, acc_write_o, acc_bank_o, burst_busy_o, proto_err_o, emr_err_o;
    logic [8:0]  acc_col_o;
    logic [10:0] mode_reg_o, ext_mode_o;
    logic [2:0]  pwr_mode_o;

    int checks = 0, errors = 0;

    // expected-state model
    logic [1:0]  m_open;
    logic [10:0] m_row [2];
    logic        m_av, m_aw, m_ab, m_perr, m_eerr, m_ap, m_apb;
    logic [8:0]  m_ac;
    logic [10:0] m_mr, m_emr;
    logic [3:0]  m_rem;
    logic [2:0]  m_pwr;

    always #2.5 clk = ~clk;

    sdram_cmd_front u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .bank_open_o(bank_open_o), .row_o(row_o), .acc_valid_o(acc_valid_o),
        .acc_write_o(acc_write_o), .acc_bank_o(acc_bank_o), .acc_col_o(acc_col_o),
        .burst_busy_o(burst_busy_o), .proto_err_o(proto_err_o),
        .mode_reg_o(mode_reg_o), .ext_mode_o(ext_mode_o), .emr_err_o(emr_err_o),
        .refresh_mask_o(refresh_mask_o), .pwr_mode_o(pwr_mode_o)
    );

    function automatic logic [3:0] f_bl(input logic [2:0] c);
        case (c)
            3'd1: return 4'd2;
            3'd2: return 4'd4;
            3'd3: return 4'd8;
            default: return 4'd1;
        endcase
    endfunction

    function automatic logic [1:0] f_mask(input logic [10:0] e);
        if (e[2:0] == 3'b001) return e[7] ? 2'b10 : 2'b01;
        return 2'b11;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [2:0] code;
        logic go, rw, ok, apd, busy, anyo;
        logic [1:0] nopen;
        if (!rst_n) begin
            m_open = '0; m_row[0] = '0; m_row[1] = '0;
            m_av = 0; m_aw = 0; m_ab = 0; m_ac = '0; m_perr = 0; m_eerr = 0;
            m_ap = 0; m_apb = 0; m_mr = '0; m_emr = '0; m_rem = '0; m_pwr = 3'd0;
            return;
        end
        code = {ras_n, cas_n, we_n};
        go   = cke && !cs_n;
        busy = (m_rem != 0);
        anyo = |m_open;
        rw   = go && (code == 3'b101 || code == 3'b100);
        ok   = rw && m_open[ba];
        apd  = cke && m_ap && m_rem == 4'd1 && !ok;
        // power state (R10, R11)
        if (m_pwr == 3'd0) begin
            if (!cke) begin
                if (busy) m_pwr = 3'd4;
                else if (anyo) m_pwr = 3'd3;
                else if (!cs_n && code == 3'b001) m_pwr = 3'd2;
                else m_pwr = 3'd1;
            end
        end else if (cke) m_pwr = 3'd0;
        // banks (R3, R4, R6)
        nopen = m_open;
        if (go && code == 3'b010) begin
            if (addr[10]) nopen = 2'b00; else nopen[ba] = 1'b0;
        end
        if (apd) nopen[m_apb] = 1'b0;
        if (go && code == 3'b011) begin nopen[ba] = 1'b1; m_row[ba] = addr; end
        // mode registers (R7, R8)
        if (go && code == 3'b000) begin
            if (!ba) m_mr_next(addr);
            else if (addr[10:8] == 0 && !anyo && !busy) m_emr = addr;
            else m_eerr = 1;
        end
        // access and burst (R1, R5, R6)
        m_av = ok;
        if (rw && !ok) m_perr = 1;
        if (ok) begin
            m_aw = (code == 3'b100); m_ab = ba; m_ac = addr[8:0];
            m_rem = f_bl(m_mr_old[2:0]); m_ap = addr[10]; m_apb = ba;
        end else if (cke && m_rem != 0) begin
            m_rem = m_rem - 1;
            if (apd) m_ap = 0;
        end
        m_mr = m_mr_new;
        m_open = nopen;
    endtask

    // base mode register written after the burst length is taken from the old value
    logic [10:0] m_mr_old, m_mr_new;
    task automatic m_mr_next(input logic [10:0] v);
        m_mr_new = v;
    endtask

    task automatic compare();
        chk("R3/R4 bank_open", bank_open_o, m_open);
        chk("R3 row", row_o, {m_row[1], m_row[0]});
        chk("R1 acc_valid", acc_valid_o, m_av);
        if (m_av) begin
            chk("R1 acc_write", acc_write_o, m_aw);
            chk("R1 acc_bank", acc_bank_o, m_ab);
            chk("R1 acc_col", acc_col_o, m_ac);
        end
        chk("R6 burst_busy", burst_busy_o, m_rem != 0);
        chk("R5 proto_err", proto_err_o, m_perr);
        chk("R7 mode_reg", mode_reg_o, m_mr);
        chk("R8 ext_mode", ext_mode_o, m_emr);
        chk("R8 emr_err", emr_err_o, m_eerr);
        chk("R9 refresh_mask", refresh_mask_o, f_mask(m_emr));
        chk("R10 pwr_mode", pwr_mode_o, m_pwr);
    endtask

    task automatic cyc(input logic k, input logic c, input logic [2:0] code,
                       input logic b, input logic [10:0] a);
        cke = k; cs_n = c; {ras_n, cas_n, we_n} = code; ba = b; addr = a;
        @(posedge clk);
        m_mr_old = m_mr; m_mr_new = m_mr;
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic cmd(input logic [2:0] code, input logic b, input logic [10:0] a);
        cyc(1'b1, 1'b0, code, b, a);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) cmd(3'b111, 1'b0, 11'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R12: reset state
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 3'b111, 1'b0, 11'd0);
        chk("R12 reset mask", refresh_mask_o, 2'b11);
        chk("R12 reset pwr", pwr_mode_o, 3'd0);
        rst_n = 1'b1;
        nop(1);
        // R7: burst length 4
        cmd(3'b000, 1'b0, 11'h002);
        chk("R7 mode load", mode_reg_o, 11'h002);
        // R8: illegal field bits while idle
        cmd(3'b000, 1'b1, 11'h101);
        chk("R8 field reject", ext_mode_o, 11'h000);
        chk("R8 field err", emr_err_o, 1'b1);
        // R5: read of idle bank
        cmd(3'b101, 1'b1, 11'h010);
        chk("R5 idle read", proto_err_o, 1'b1);
        // R3: open bank 0
        cmd(3'b011, 1'b0, 11'h5A5);
        chk("R3 row0", row_o[10:0], 11'h5A5);
        // R6/R10/R11: read with auto precharge, suspended mid-burst
        cmd(3'b101, 1'b0, 11'h5FF);
        chk("R1 col", acc_col_o, 9'h1FF);
        cyc(1'b0, 1'b0, 3'b111, 1'b0, 11'd0);
        chk("R10 suspend", pwr_mode_o, 3'd4);
        cyc(1'b0, 1'b0, 3'b011, 1'b1, 11'd7);
        chk("R11 no cmd while cke low", bank_open_o, 2'b01);
        nop(4);
        chk("R6 auto precharge closed", bank_open_o, 2'b00);
        // R4: single and all-bank precharge
        cmd(3'b011, 1'b0, 11'h011);
        cmd(3'b011, 1'b1, 11'h722);
        cmd(3'b010, 1'b0, 11'h000);
        chk("R4 single close", bank_open_o, 2'b10);
        cyc(1'b0, 1'b0, 3'b111, 1'b0, 11'd0);
        chk("R10 active pd", pwr_mode_o, 3'd3);
        cmd(3'b010, 1'b0, 11'h400);
        chk("R11 wake", pwr_mode_o, 3'd0);
        chk("R4 all close", bank_open_o, 2'b00);
        // R8/R9: legal one-bank refresh of bank 1
        cmd(3'b000, 1'b1, 11'h081);
        chk("R9 mask bank1", refresh_mask_o, 2'b10);
        cmd(3'b000, 1'b1, 11'h001);
        chk("R9 mask bank0", refresh_mask_o, 2'b01);
        // R10: self refresh and precharge power-down
        cyc(1'b0, 1'b0, 3'b001, 1'b0, 11'd0);
        chk("R10 self refresh", pwr_mode_o, 3'd2);
        nop(1);
        cyc(1'b0, 1'b0, 3'b111, 1'b0, 11'd0);
        chk("R10 precharge pd", pwr_mode_o, 3'd1);
        nop(1);
        // R2: deselected activate
        cyc(1'b1, 1'b1, 3'b011, 1'b0, 11'h123);
        chk("R2 deselect", bank_open_o, 2'b00);
        // random mix
        for (int n = 0; n < 6000; n++) begin
            logic [2:0] code;
            int r;
            r = $urandom % 100;
            case ($urandom % 9)
                0, 1: code = 3'b011;
                2, 3: code = 3'b101;
                4:    code = 3'b100;
                5:    code = 3'b010;
                6:    code = 3'b001;
                7:    code = 3'b000;
                default: code = 3'b111;
            endcase
            cyc(r >= 7, ($urandom % 10) == 0, code, 1'($urandom),
                (code == 3'b000 && ($urandom % 2)) ? 11'($urandom % 256) : 11'($urandom));
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule